// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a byte-wide NOR flash model. It watches bus write cycles, which are formed from an active-low chip enable and an active-low write enable, together with the address and data buses. It recognises the unlock-prefixed command sequences for byte program, chip erase, identification (autoselect) and return-to-read. Completed program and erase sequences go to a separate embedded-algorithm controller as a one-cycle start pulse, with the target address and byte held alongside.

Reads are combinational from the live address. In identification mode the block returns the manufacturer byte, the device byte, or the protection status of the addressed sector, and every one of these bytes carries odd parity in bit 7. Outside that mode, reads pass the array data straight through. The strobes are synchronous to `clk`. A write cycle opens in the first clock where both enables are low. It closes in the first clock where either enable is high again.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, `autosel_o` is 0, both start pulses are 0, and `rdata_o` equals `array_rdata_i`.
- R2: A write takes its address from the first cycle where both enables are low, which is the later of the two falling edges. It takes its data from the last cycle where both are low, which is before the earlier rising edge. Address changes after the opening cycle have no effect, and data changes after the closing edge have no effect.
- R3: The writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by any write at any address, give `prog_start_o`=1 for exactly one cycle. The pulse comes in the cycle after that last write closes, with `cmd_addr_o`/`cmd_data_o` equal to its address and data. The data byte may take any value, F0h included.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh and 10h@5555h give `erase_start_o`=1 for one cycle, in the cycle after the sixth write closes.
- R5: The writes AAh@5555h, 55h@2AAAh and 90h@5555h set `autosel_o`. Once it is set, a read with address low byte 00h returns 01h, and a read with low byte 01h returns A4h.
- R6: In identification mode, a read with low byte 02h returns 01h if the sector is protected and 80h if it is not. The sector is selected by the top `SECT_W` address bits, which index `prot_i`.
- R7: In identification mode, any other low byte returns 80h. Every identification byte has odd parity over all 8 bits, with bit 7 as the parity bit.
- R8: Identification mode stays on through reads and through other writes. A write of data F0h at any address turns it off, unless the sequencer is waiting for the program data.
- R9: A write that does not match the next expected step of a sequence returns the sequencer to idle, so a later lone data write starts nothing.
- R10: While `busy_i` is 1, writes do not advance any sequence and do not enter identification mode. A write of F0h still clears the mode and the sequencer.
- R11: Start pulses never overlap and never last more than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Bus address |
| wdata_i | input | 8 | Bus write data |
| array_rdata_i | input | 8 | Read data from the cell array |
| busy_i | input | 1 | Embedded controller busy |
| prot_i | input | 2**SECT_W | Per-sector protection flags |
| rdata_o | output | 8 | Bus read data |
| autosel_o | output | 1 | Identification mode active |
| prog_start_o | output | 1 | Byte program start pulse |
| erase_start_o | output | 1 | Chip erase start pulse |
| cmd_addr_o | output | ADDR_W | Program target address |
| cmd_data_o | output | 8 | Program data byte |

## Verification
The hardest situation to reach from the ports is a write whose bus values move inside the strobe window. To get there, every bench write changes the address after the opening cycle and corrupts the data on the closing edge. One variant also lowers write enable before chip enable, with a wrong address presented in between. A wrong capture edge then shows up as a wrong `cmd_addr_o` or `cmd_data_o`. The bench also interleaves busy periods with a pending identification mode, to show that only the return-to-read byte gets through.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int CMP_W = 16;
  localparam logic [CMP_W-1:0] UNLOCK_A1 = 16'h5555;
  localparam logic [CMP_W-1:0] UNLOCK_A2 = 16'h2AAA;
  localparam logic [7:0] UNLOCK_D1  = 8'hAA;
  localparam logic [7:0] UNLOCK_D2  = 8'h55;
  localparam logic [7:0] OP_PROGRAM = 8'hA0;
  localparam logic [7:0] OP_IDENT   = 8'h90;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_RETURN  = 8'hF0;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_UNL1, SQ_UNL2, SQ_PROG, SQ_ERS0, SQ_ERS1, SQ_ERS2
  } seq_state_t;

  function automatic logic [7:0] odd_par(input logic [6:0] v);
    return {~^v, v};
  endfunction
endpackage

// File: rtl/fcd_bus_capture.sv
module fcd_bus_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              act, act_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  // both enables low: window opens at the later fall, closes at the earlier rise
  always_comb begin
    act    = ~ce_n & ~we_n;
    addr_d = (act & ~act_q) ? addr_i : addr_q;
    data_d = act ? data_i : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q  <= act;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_stb_o  = act_q & ~act;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;
endmodule

// File: rtl/fcd_sequencer.sv
module fcd_sequencer
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              busy_i,
  output logic              autosel_o,
  output logic              prog_start_o,
  output logic              erase_start_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [7:0]        cmd_data_o
);
  seq_state_t        st_q, st_d;
  logic              as_q, as_d;
  logic              ps_q, ps_d, es_q, es_d;
  logic [ADDR_W-1:0] ca_q, ca_d;
  logic [7:0]        cd_q, cd_d;
  logic              at_a1, at_a2, is_u1, is_u2, want_data;

  always_comb begin
    at_a1     = (wr_addr_i[CMP_W-1:0] == UNLOCK_A1);
    at_a2     = (wr_addr_i[CMP_W-1:0] == UNLOCK_A2);
    is_u1     = at_a1 && (wr_data_i == UNLOCK_D1);
    is_u2     = at_a2 && (wr_data_i == UNLOCK_D2);
    want_data = (st_q == SQ_PROG) && !busy_i;

    st_d = st_q;
    as_d = as_q;
    ps_d = 1'b0;
    es_d = 1'b0;
    ca_d = ca_q;
    cd_d = cd_q;
    if (wr_stb_i) begin
      if ((wr_data_i == OP_RETURN) && !want_data) begin
        st_d = SQ_IDLE;
        as_d = 1'b0;
      end else if (!busy_i) begin
        st_d = SQ_IDLE;
        unique case (st_q)
          SQ_IDLE: if (is_u1) st_d = SQ_UNL1;
          SQ_UNL1: if (is_u2) st_d = SQ_UNL2;
          SQ_UNL2: begin
            if (at_a1 && wr_data_i == OP_PROGRAM)    st_d = SQ_PROG;
            else if (at_a1 && wr_data_i == OP_ERASE) st_d = SQ_ERS0;
            else if (at_a1 && wr_data_i == OP_IDENT) as_d = 1'b1;
          end
          SQ_PROG: begin
            ps_d = 1'b1;
            ca_d = wr_addr_i;
            cd_d = wr_data_i;
          end
          SQ_ERS0: if (is_u1) st_d = SQ_ERS1;
          SQ_ERS1: if (is_u2) st_d = SQ_ERS2;
          SQ_ERS2: if (at_a1 && wr_data_i == OP_CHIP) es_d = 1'b1;
          default: st_d = SQ_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
      as_q <= 1'b0;
      ps_q <= 1'b0;
      es_q <= 1'b0;
      ca_q <= '0;
      cd_q <= '0;
    end else begin
      st_q <= st_d;
      as_q <= as_d;
      ps_q <= ps_d;
      es_q <= es_d;
      ca_q <= ca_d;
      cd_q <= cd_d;
    end
  end

  assign autosel_o     = as_q;
  assign prog_start_o  = ps_q;
  assign erase_start_o = es_q;
  assign cmd_addr_o    = ca_q;
  assign cmd_data_o    = cd_q;
endmodule

// File: rtl/fcd_ident.sv
module fcd_ident
  import fcd_pkg::*;
#(
  parameter int SECT_W = 3,
  parameter logic [6:0] MFR_ID7 = 7'h01,
  parameter logic [6:0] DEV_ID7 = 7'h24
) (
  input  logic [7:0]            low_byte_i,
  input  logic [SECT_W-1:0]     sector_i,
  input  logic [(1<<SECT_W)-1:0] prot_i,
  output logic [7:0]            code_o
);
  always_comb begin
    unique case (low_byte_i)
      8'h00:   code_o = odd_par(MFR_ID7);
      8'h01:   code_o = odd_par(DEV_ID7);
      8'h02:   code_o = odd_par({6'd0, prot_i[sector_i]});
      default: code_o = odd_par(7'd0);
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 3,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  input  logic [7:0]        array_rdata_i,
  input  logic              busy_i,
  input  logic [NSECT-1:0]  prot_i,
  output logic [7:0]        rdata_o,
  output logic              autosel_o,
  output logic              prog_start_o,
  output logic              erase_start_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [7:0]        cmd_data_o
);
  logic              wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [7:0]        id_code;

  fcd_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(8)) u_cap (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n),
    .addr_i(addr_i), .data_i(wdata_i),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  fcd_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_stb_i(wr_stb), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy_i), .autosel_o(autosel_o),
    .prog_start_o(prog_start_o), .erase_start_o(erase_start_o),
    .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o)
  );

  fcd_ident #(.SECT_W(SECT_W)) u_id (
    .low_byte_i(addr_i[7:0]), .sector_i(addr_i[ADDR_W-1 -: SECT_W]),
    .prot_i(prot_i), .code_o(id_code)
  );

  assign rdata_o = autosel_o ? id_code : array_rdata_i;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy_i,
  input logic       wr_stb,
  input logic [7:0] wr_data,
  input logic [7:0] rdata_o,
  input logic       autosel_o,
  input logic       prog_start_o,
  input logic       erase_start_o
);
  a_r11_prog_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start_o |=> !prog_start_o);
  a_r11_erase_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start_o |=> !erase_start_o);
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start_o, erase_start_o}));
  a_r10_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_start_o) || $rose(erase_start_o) |-> $past(wr_stb) && !$past(busy_i));
  a_r5_entry_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(autosel_o) |-> $past(wr_stb) && $past(wr_data) == 8'h90 && !$past(busy_i));
  a_r8_exit_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(autosel_o) |-> $past(wr_stb) && $past(wr_data) == 8'hF0);
  a_r7_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
    autosel_o |-> ^rdata_o);
endmodule

bind flash_cmd_decoder fcd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy_i(busy_i), .wr_stb(wr_stb),
  .wr_data(wr_data), .rdata_o(rdata_o), .autosel_o(autosel_o),
  .prog_start_o(prog_start_o), .erase_start_o(erase_start_o)
);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_n = 1'b1, we_n = 1'b1, busy_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0]  wdata_i = '0, array_rdata_i = 8'h3C;
  logic [7:0]  prot_i = 8'b0010_0000;
  logic [7:0]  rdata_o, cmd_data_o;
  logic [15:0] cmd_addr_o;
  logic        autosel_o, prog_start_o, erase_start_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  flash_cmd_decoder uut (.*);

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // address moves after opening cycle, data corrupted on closing edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk) addr_i = a; wdata_i = 8'h00; ce_n = 1'b0;
    @(negedge clk) we_n = 1'b0; wdata_i = d;
    @(negedge clk) addr_i = ~a;
    @(negedge clk) we_n = 1'b1; wdata_i = ~d;
    @(negedge clk) ce_n = 1'b1;
  endtask

  // write enable falls first with a wrong address; chip enable falls later
  task automatic wr_ce_late(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk) addr_i = 16'h0BAD; wdata_i = d; we_n = 1'b0;
    @(negedge clk) addr_i = a; ce_n = 1'b0;
    @(negedge clk) addr_i = 16'h0BAD;
    @(negedge clk) ce_n = 1'b1; wdata_i = 8'h00;
    @(negedge clk) we_n = 1'b1;
  endtask

  task automatic unlock();
    wr(16'h5555, 8'hAA);
    wr(16'h2AAA, 8'h55);
  endtask

  task automatic rd(string tag, input logic [15:0] a, input logic [7:0] exp);
    @(negedge clk) addr_i = a;
    #1 chk(tag, {8'h00, rdata_o}, {8'h00, exp});
  endtask

  task automatic t_reset();
    chk("R1 autosel", {15'd0, autosel_o}, 16'd0);
    chk("R1 starts", {14'd0, prog_start_o, erase_start_o}, 16'd0);
    chk("R1 passthrough", {8'h00, rdata_o}, 16'h003C);
  endtask

  task automatic t_program();
    unlock();
    wr(16'h5555, 8'hA0);
    wr_ce_late(16'hE123, 8'h5A);
    chk("R3 prog pulse", {15'd0, prog_start_o}, 16'd1);
    chk("R2 latched addr", cmd_addr_o, 16'hE123);
    chk("R2 latched data", {8'h00, cmd_data_o}, 16'h005A);
    @(negedge clk) chk("R11 prog one cycle", {15'd0, prog_start_o}, 16'd0);
    unlock();
    wr(16'h5555, 8'hA0);
    wr(16'h0010, 8'hF0);
    chk("R3 prog F0 byte", {15'd0, prog_start_o}, 16'd1);
    chk("R2 addr after move", cmd_addr_o, 16'h0010);
    chk("R3 data F0", {8'h00, cmd_data_o}, 16'h00F0);
  endtask

  task automatic t_erase();
    unlock();
    wr(16'h5555, 8'h80);
    unlock();
    wr(16'h5555, 8'h10);
    chk("R4 erase pulse", {15'd0, erase_start_o}, 16'd1);
    chk("R11 no overlap", {15'd0, prog_start_o}, 16'd0);
    @(negedge clk) chk("R11 erase one cycle", {15'd0, erase_start_o}, 16'd0);
  endtask

  task automatic t_ident();
    unlock();
    wr(16'h5555, 8'h90);
    chk("R5 autosel set", {15'd0, autosel_o}, 16'd1);
    rd("R5 mfr code", 16'h3400, 8'h01);
    rd("R5 dev code", 16'h3401, 8'hA4);
    rd("R6 protected sector", 16'hA002, 8'h01);
    rd("R6 open sector", 16'h2002, 8'h80);
    rd("R7 other byte", 16'h0055, 8'h80);
    wr(16'h1234, 8'hAA);
    chk("R8 persists after write", {15'd0, autosel_o}, 16'd1);
    rd("R8 still ident", 16'h7701, 8'hA4);
    wr(16'h0000, 8'hF0);
    chk("R8 exit", {15'd0, autosel_o}, 16'd0);
    rd("R8 back to array", 16'h0001, 8'h3C);
  endtask

  task automatic t_mismatch();
    unlock();
    wr(16'h5555, 8'h33);
    wr(16'h0100, 8'h77);
    chk("R9 bad command", {15'd0, prog_start_o}, 16'd0);
    wr(16'h5555, 8'hAA);
    wr(16'h5555, 8'hA0);
    wr(16'h0100, 8'h77);
    chk("R9 skipped unlock", {15'd0, prog_start_o}, 16'd0);
    unlock();
    wr(16'h5555, 8'hA0);
    wr(16'h0200, 8'h66);
    chk("R9 recovers", {15'd0, prog_start_o}, 16'd1);
  endtask

  task automatic t_busy();
    @(negedge clk) busy_i = 1'b1;
    unlock();
    wr(16'h5555, 8'hA0);
    wr(16'h0300, 8'h11);
    chk("R10 no prog busy", {15'd0, prog_start_o}, 16'd0);
    unlock();
    wr(16'h5555, 8'h90);
    chk("R10 no ident busy", {15'd0, autosel_o}, 16'd0);
    @(negedge clk) busy_i = 1'b0;
    wr(16'h0300, 8'h11);
    chk("R10 seq not advanced", {15'd0, prog_start_o}, 16'd0);
    unlock();
    wr(16'h5555, 8'h90);
    @(negedge clk) busy_i = 1'b1;
    wr(16'h4444, 8'hF0);
    chk("R10 reset while busy", {15'd0, autosel_o}, 16'd0);
    @(negedge clk) busy_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program();
    t_erase();
    t_ident();
    t_mismatch();
    t_busy();
    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule